// File: doc/BRIEF.md
# Emulated Double-Data-Rate Output Register

This block drives a double-data-rate output using only ordinary single-edge flip-flops. It is meant for outputs that have no dedicated two-edge output cell. Each output lane has two data inputs. One gives the value shown for the high half of the clock period. The other gives the value shown for the low half.

Each lane holds two registers. One is clocked on the rising edge and the other on the falling edge. The output is the XOR of the two registers. Each register loads its own new value XORed with the other register's current content. After any edge the XOR therefore equals the value just captured. Only one register changes at a time, so the output can only move after a clock edge and never carries a runt pulse.

A gating state machine samples the enable on the rising edge. Its two states are GATE_PARKED and GATE_LIVE. The transition ARM (enable high while parked) moves it to GATE_LIVE. The transition DROP (enable low while live) moves it back to GATE_PARKED. The two hold transitions (enable high while live, enable low while parked) leave the state unchanged. A cycle whose rising edge sees the enable low shows the park value in both of its halves. Tying the high-half input to one and the low-half input to zero makes the block forward the clock, and the enable then switches that clock replica on and off on whole periods.

Top module: `ddr_emu_out`

## Requirements
- R1: While the active-low reset is asserted, every bit of `q` reads 0, whatever the clock and data inputs do.
- R2: If `en` is 1 at a rising edge, then for the whole high half that follows, `q` equals `d_rise` as sampled at that edge.
- R3: If `en` was 1 at the latest rising edge, then for the whole low half that follows the next falling edge, `q` equals `d_fall` as sampled at that falling edge.
- R4: With `d_rise` all ones, `d_fall` all zeros and `en` held at 1, every lane of `q` is 1 in each high half and 0 in each low half, which replicates the clock at its own frequency.
- R5: If `en` is 0 at a rising edge, `q` shows the park value `PARK` (default all zeros) in both halves of that period. A change of `en` during a period has no effect before the next rising edge.
- R6: `q` changes only just after a clock edge. Within each half period its value stays constant.
- R7: Lanes are independent. Each bit of `q` follows only the same bit of `d_rise` and `d_fall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both edges are used. |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output enable, sampled on the rising edge |
| d_rise | input | WIDTH | Value shown during the high half |
| d_fall | input | WIDTH | Value shown during the low half |
| q | output | WIDTH | Double-data-rate output |

## Verification
Every result is due half a period after its stimulus is sampled. The value captured at a rising edge appears just after that edge, and the value captured at a falling edge appears just after that falling edge. The enable taken at a rising edge governs both halves of that period. The bench model therefore records expected levels at each edge from the inputs present there, and it reads `q` twice inside the following half, 1 ns and 1.5 ns after the edge. It never reads at an edge. Inputs change only 0.5 ns after an edge, so every sampled value is unambiguous. The second read in each half detects any extra transition.

// File: rtl/ddr_emu_pkg.sv
package ddr_emu_pkg;

    // Gating state, updated on the rising edge only
    typedef enum logic [0:0] {
        GATE_PARKED = 1'b0,
        GATE_LIVE   = 1'b1
    } gate_state_t;

endpackage

// File: rtl/ddr_gate_fsm.sv
module ddr_gate_fsm
    import ddr_emu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic rise_use,
    output logic fall_use
);

    gate_state_t state_q;
    gate_state_t state_d;

    // Next-state logic: ARM and DROP transitions, otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_PARKED: if (en)  state_d = GATE_LIVE;    // ARM
            GATE_LIVE:   if (!en) state_d = GATE_PARKED;  // DROP
            default:     state_d = GATE_PARKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_PARKED;
        else        state_q <= state_d;
    end

    // Outputs: the rising register follows the state being entered,
    // the falling register follows the state held over the period
    always_comb begin
        rise_use = 1'b0;
        fall_use = 1'b0;
        unique case (state_d)
            GATE_LIVE:   rise_use = 1'b1;
            GATE_PARKED: rise_use = 1'b0;
            default:     rise_use = 1'b0;
        endcase
        unique case (state_q)
            GATE_LIVE:   fall_use = 1'b1;
            GATE_PARKED: fall_use = 1'b0;
            default:     fall_use = 1'b0;
        endcase
    end

endmodule

// File: rtl/ddr_lane_pair.sv
module ddr_lane_pair #(
    parameter logic PARK_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_use,
    input  logic fall_use,
    input  logic d_rise,
    input  logic d_fall,
    output logic q
);

    logic hi_reg;
    logic lo_reg;
    logic hi_val;
    logic lo_val;

    assign hi_val = rise_use ? d_rise : PARK_BIT;
    assign lo_val = fall_use ? d_fall : PARK_BIT;

    // Rising-edge register: after the update, hi_reg ^ lo_reg == hi_val
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_reg <= 1'b0;
        else        hi_reg <= lo_reg ^ hi_val;
    end

    // Falling-edge register: after the update, hi_reg ^ lo_reg == lo_val
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lo_reg <= 1'b0;
        else        lo_reg <= hi_reg ^ lo_val;
    end

    // Only one input of the XOR changes per edge
    assign q = hi_reg ^ lo_reg;

endmodule

// File: rtl/ddr_emu_out.sv
module ddr_emu_out #(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] PARK  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d_rise,
    input  logic [WIDTH-1:0] d_fall,
    output logic [WIDTH-1:0] q
);

    logic rise_use;
    logic fall_use;

    ddr_gate_fsm u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rise_use (rise_use),
        .fall_use (fall_use)
    );

    for (genvar li = 0; li < WIDTH; li++) begin : g_lane
        ddr_lane_pair #(
            .PARK_BIT (PARK[li])
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_use (rise_use),
            .fall_use (fall_use),
            .d_rise   (d_rise[li]),
            .d_fall   (d_fall[li]),
            .q        (q[li])
        );
    end

endmodule

// File: rtl/ddr_emu_out_chk.sv
module ddr_emu_out_chk #(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] PARK  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [WIDTH-1:0] d_rise,
    input logic [WIDTH-1:0] d_fall,
    input logic [WIDTH-1:0] q
);

    logic             hi_ok, lo_ok;
    logic             c_live, c_lo_live;
    logic [WIDTH-1:0] c_hi, c_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_ok  <= 1'b0;
            c_live <= 1'b0;
            c_hi   <= '0;
        end else begin
            hi_ok  <= 1'b1;
            c_live <= en;
            c_hi   <= en ? d_rise : PARK;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_ok     <= 1'b0;
            c_lo_live <= 1'b0;
            c_lo      <= '0;
        end else begin
            lo_ok     <= hi_ok;
            c_lo_live <= c_live;
            c_lo      <= c_live ? d_fall : PARK;
        end
    end

    // R1
    reset_low_chk: assert property (@(negedge clk) !rst_n |-> q == '0);

    // R2
    high_half_chk: assert property (@(negedge clk) disable iff (!rst_n)
        hi_ok |-> q == c_hi);

    // R3
    low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ok |-> q == c_lo);

    // R5
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_ok && !c_lo_live) |-> q == PARK);

endmodule

bind ddr_emu_out ddr_emu_out_chk #(
    .WIDTH (WIDTH),
    .PARK  (PARK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .d_rise (d_rise),
    .d_fall (d_fall),
    .q      (q)
);

// File: tb/tb_ddr_emu_out.sv
`timescale 1ns/1ps
module tb_ddr_emu_out;

    localparam int               W    = 4;
    localparam logic [W-1:0]     PARK = '0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] d_rise = '0;
    logic [W-1:0] d_fall = '0;
    logic [W-1:0] q;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    bit fwd_mode = 0;
    bit lane_mode = 0;

    always #2 clk = ~clk;  // 250 MHz

    ddr_emu_out #(.WIDTH(W), .PARK(PARK)) dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .d_rise(d_rise), .d_fall(d_fall), .q(q)
    );

    // Behavioural reference: expected levels recorded at each edge
    logic [W-1:0] m_hi = '0, m_lo = '0;
    bit m_live = 0, m_lo_live = 0;

    always @(posedge clk) begin
        m_live = rst_n && en;
        m_hi   = !rst_n ? '0 : (m_live ? d_rise : PARK);
    end
    always @(negedge clk) begin
        m_lo_live = m_live;
        m_lo      = !rst_n ? '0 : (m_live ? d_fall : PARK);
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(bit high, bit live);
        if (!rst_n)    return "R1";
        if (fwd_mode)  return "R4";
        if (lane_mode) return "R7";
        if (!live)     return "R5";
        return high ? "R2" : "R3";
    endfunction

    // Sampler: two reads inside every half period
    initial begin
        logic [W-1:0] first;
        forever begin
            @(posedge clk);
            #1;
            first = q;
            chk(tag_for(1, m_live), q, !rst_n ? '0 : m_hi);
            #0.5;
            chk("R6", q, first);
            @(negedge clk);
            #1;
            first = q;
            chk(tag_for(0, m_lo_live), q, !rst_n ? '0 : m_lo);
            #0.5;
            chk("R6", q, first);
        end
    end

    task automatic step(bit e, logic [W-1:0] r, logic [W-1:0] f);
        @(negedge clk);
        #0.5;
        en = e; d_rise = r; d_fall = f;
    endtask

    initial begin
        // R1: reset with busy inputs
        for (int i = 0; i < 4; i++) step(1'b1, '1, 4'b1010);
        @(negedge clk); #0.5 rst_n = 1'b1;

        // R4: clock forwarding
        fwd_mode = 1;
        for (int i = 0; i < 12; i++) step(1'b1, '1, '0);
        fwd_mode = 0;

        // R2 / R3: random data, enabled
        for (int i = 0; i < 60; i++) step(1'b1, W'($urandom), W'($urandom));

        // R7: lanes driven with opposing patterns
        lane_mode = 1;
        for (int i = 0; i < 16; i++) step(1'b1, W'(1 << (i % W)), ~W'(1 << (i % W)));
        lane_mode = 0;

        // R5: random enable per period
        for (int i = 0; i < 80; i++) step(1'($urandom), W'($urandom), W'($urandom));

        // R5: enable toggled inside the high half has no effect until the next rising edge
        for (int i = 0; i < 20; i++) begin
            step(1'(i % 2), W'($urandom), W'($urandom));
            @(posedge clk); #0.5 en = ~en;
        end

        // R4 again, switched off and on with the enable
        fwd_mode = 1;
        for (int i = 0; i < 20; i++) step(1'(i % 3 != 0), '1, '0);
        fwd_mode = 0;

        // R1: reset asserted during activity
        step(1'b1, '1, '1);
        @(negedge clk); #0.5 rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, '1, '1);
        @(negedge clk); #0.5 rst_n = 1'b1;
        for (int i = 0; i < 10; i++) step(1'b1, W'($urandom), W'($urandom));

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule